// File: doc/BRIEF.md
# Character-Packing I/O Buffer

This block sits between a peripheral that moves one 6-bit character at a time and a 24-bit word port. In receive mode it checks the parity of each incoming character and places the character into a word register. It signals that the word is complete once the configured number of characters has arrived. In send mode it takes a whole word and hands it out one character per device request, with a generated parity bit on each character.

A single activate command sets the direction, the parity sense and the number of characters per word, clears all status and connects the device. An end-of-record gap on receive ends the transfer early and zero-fills a partial word. Software can end a send transfer in two ways: drop the device at once, or let the buffer drain and then disconnect with an interrupt.

Top module: `chpk_buffer`

## Requirements
- R1: While reset is applied and just after it, dev_disc is 1 and buf_ready, buf_error, irq_req and dev_out_stb are 0.
- R2: cfg_cpw selects the characters per word as code+1 (00 gives 1, 11 gives 4). In receive mode (cfg_out=0), the k-th accepted character (k from 0) is stored at word_rdata bits [23-6k : 18-6k]. buf_ready rises in the cycle after the last character of the word is accepted.
- R3: With cfg_even=0 a character is valid when its 6 data bits plus dev_in_par hold an odd number of ones. With cfg_even=1 the count must be even. On a mismatch, buf_error is set and the data bits are still stored. buf_error stays set until the next activate.
- R4: A word_rd pulse while receive-mode buf_ready is 1 empties the buffer. In the next cycle buf_ready is 0 and word_rdata is 0.
- R5: A character that arrives while a full word is still unread is discarded. buf_error is set and word_rdata does not change.
- R6: dev_in_gap on receive disconnects the device (dev_disc=1) and sets irq_req. If some characters are already held, buf_ready is set and the unfilled low-order bits read as zero.
- R7: In send mode (cfg_out=1), each dev_out_req produces dev_out_stb in the next cycle. That cycle carries the next character from the most significant end of the word, with parity by the rule of R3. With one character per word, bits [23:18] are sent.
- R8: In send mode buf_ready is 1 while the buffer holds no unsent character. A word_wr is taken only while buf_ready is 1, and a word_wr while it is 0 has no effect.
- R9: A dev_out_req while the send buffer is empty produces a blank character: data 0, parity 1 with cfg_even=0 and parity 0 with cfg_even=1.
- R10: cmd_drop disconnects the device in the next cycle without setting irq_req, even with characters pending. After that, dev_out_req gives no dev_out_stb.
- R11: After cmd_drain in send mode, the pending characters are still sent on request. One cycle after the last one goes out, dev_disc and irq_req become 1.
- R12: While disconnected, incoming characters are ignored: buf_ready, buf_error and word_rdata are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_activate | input | 1 | Pulse: load configuration, clear status, connect |
| cfg_out | input | 1 | Direction at activate: 0 receive, 1 send |
| cfg_even | input | 1 | Parity sense at activate: 0 odd, 1 even |
| cfg_cpw | input | 2 | Characters per word minus one, at activate |
| cmd_drop | input | 1 | Pulse: disconnect at once, no interrupt |
| cmd_drain | input | 1 | Pulse: send remaining characters, then disconnect with interrupt |
| dev_in_vld | input | 1 | Incoming character valid |
| dev_in_char | input | 6 | Incoming character data |
| dev_in_par | input | 1 | Incoming character parity bit |
| dev_in_gap | input | 1 | End-of-record gap seen on receive |
| dev_out_req | input | 1 | Device asks for the next character |
| dev_out_stb | output | 1 | Outgoing character valid |
| dev_out_char | output | 6 | Outgoing character data |
| dev_out_par | output | 1 | Outgoing character parity bit |
| word_rd | input | 1 | Word taken from the buffer (receive) |
| word_rdata | output | 24 | Assembled word |
| word_wr | input | 1 | Word written into the buffer (send) |
| word_wdata | input | 24 | Word to send |
| buf_ready | output | 1 | Word complete (receive) or buffer drained (send) |
| buf_error | output | 1 | Sticky parity or overrun error |
| dev_disc | output | 1 | Device disconnected |
| irq_req | output | 1 | Sticky interrupt request, cleared by activate |

## Verification
Some properties are checked on every cycle. No strobe appears while disconnected. An overrun always raises the error flag. A full receive word survives until it is read. A clear really empties the word. The interrupt stays set until activate, and an immediate drop never raises it. Only the bench scenarios can show the rest. These are the bit position of each character under every width code, the parity sense in both modes, zero fill after a gap, the blank character on underrun, and the drain ordering in which the last character leaves before the disconnect and interrupt.

// File: rtl/chpk_pkg.sv
package chpk_pkg;
  typedef enum logic {
    XFER_IN  = 1'b0,
    XFER_OUT = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/chpk_parity.sv
// Parity bit that makes the total ones count odd (even_mode=0) or even.
module chpk_parity #(
  parameter int W = 6
) (
  input  logic [W-1:0] data,
  input  logic         even_mode,
  output logic         par_bit
);
  always_comb begin
    par_bit = even_mode ? (^data) : ~(^data);
  end
endmodule

// File: rtl/chpk_slots.sv
// Word register split into character slots, slot 0 at the most significant end.
module chpk_slots #(
  parameter  int CHAR_W = 6,
  parameter  int SLOTS  = 4,
  localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int WORD_W = CHAR_W * SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ld,
  input  logic [WORD_W-1:0] ld_word,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [CHAR_W-1:0] wr_char,
  output logic [WORD_W-1:0] word_q,
  output logic [CHAR_W-1:0] sel_char
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [CHAR_W-1:0] slot_q;
    logic [CHAR_W-1:0] slot_d;
    logic              slot_en;

    always_comb begin
      slot_en = clr | ld | (wr && (idx == IDX_W'(i)));
      if (clr)     slot_d = '0;
      else if (ld) slot_d = ld_word[WORD_W-1-CHAR_W*i -: CHAR_W];
      else         slot_d = wr_char;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= slot_d;
    end

    assign word_q[WORD_W-1-CHAR_W*i -: CHAR_W] = slot_q;
  end

  always_comb begin
    sel_char = word_q[WORD_W-1-CHAR_W*int'(idx) -: CHAR_W];
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ld) |=> (word_q == '0)); // R4
endmodule

// File: rtl/chpk_seq.sv
// Transfer sequencer: connection, direction, fill level, status and output register.
module chpk_seq
  import chpk_pkg::*;
#(
  parameter  int CHAR_W = 6,
  parameter  int SLOTS  = 4,
  localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_act,
  input  logic              cfg_out,
  input  logic              cfg_even,
  input  logic [IDX_W-1:0]  cfg_cpw,
  input  logic              cmd_drop,
  input  logic              cmd_drain,
  input  logic              in_vld,
  input  logic              in_par_ok,
  input  logic              in_gap,
  input  logic              out_req,
  input  logic [CHAR_W-1:0] send_char,
  input  logic              send_par,
  input  logic              rd,
  input  logic              wr,
  output logic              slot_clr,
  output logic              slot_ld,
  output logic              slot_wr,
  output logic [IDX_W-1:0]  cnt,
  output logic              even_mode,
  output logic              buf_empty,
  output logic              ready,
  output logic              error,
  output logic              disc,
  output logic              irq,
  output logic              stb,
  output logic [CHAR_W-1:0] ochar,
  output logic              opar
);
  logic              conn_q, conn_d;
  xfer_dir_e         dir_q, dir_d;
  logic              even_q, even_d;
  logic [IDX_W-1:0]  cpw_q, cpw_d;
  logic [IDX_W-1:0]  cnt_q, cnt_d;
  logic              full_q, full_d;
  logic              empty_q, empty_d;
  logic              err_q, err_d;
  logic              irq_q, irq_d;
  logic              term_q, term_d;
  logic              stb_q, stb_d;
  logic [CHAR_W-1:0] ochar_q, ochar_d;
  logic              opar_q, opar_d;
  logic              last;

  always_comb begin
    conn_d   = conn_q;
    dir_d    = dir_q;
    even_d   = even_q;
    cpw_d    = cpw_q;
    cnt_d    = cnt_q;
    full_d   = full_q;
    empty_d  = empty_q;
    err_d    = err_q;
    irq_d    = irq_q;
    term_d   = term_q;
    stb_d    = 1'b0;
    ochar_d  = ochar_q;
    opar_d   = opar_q;
    slot_clr = 1'b0;
    slot_ld  = 1'b0;
    slot_wr  = 1'b0;
    last     = (cnt_q == cpw_q);

    if (cmd_act) begin
      conn_d   = 1'b1;
      dir_d    = cfg_out ? XFER_OUT : XFER_IN;
      even_d   = cfg_even;
      cpw_d    = cfg_cpw;
      cnt_d    = '0;
      full_d   = 1'b0;
      empty_d  = 1'b1;
      err_d    = 1'b0;
      irq_d    = 1'b0;
      term_d   = 1'b0;
      slot_clr = 1'b1;
    end else begin
      if (cmd_drop && conn_q) begin
        conn_d = 1'b0;
        term_d = 1'b0;
      end else if (conn_q && dir_q == XFER_IN) begin
        if (in_gap) begin
          conn_d = 1'b0;
          irq_d  = 1'b1;
          if (cnt_q != '0) full_d = 1'b1;
          cnt_d  = '0;
        end else if (in_vld) begin
          if (full_q) begin
            err_d = 1'b1;
          end else begin
            slot_wr = 1'b1;
            if (!in_par_ok) err_d = 1'b1;
            if (last) begin
              full_d = 1'b1;
              cnt_d  = '0;
            end else begin
              cnt_d = cnt_q + IDX_W'(1);
            end
          end
        end
      end else if (conn_q) begin
        if (out_req) begin
          stb_d   = 1'b1;
          ochar_d = send_char;
          opar_d  = send_par;
          if (!empty_q) begin
            if (last) begin
              empty_d = 1'b1;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + IDX_W'(1);
            end
          end
        end
        if (wr && empty_q && !term_q && !cmd_drain) begin
          slot_ld = 1'b1;
          empty_d = 1'b0;
          cnt_d   = '0;
        end
        if (cmd_drain) term_d = 1'b1;
        if ((term_q || cmd_drain) && empty_q) begin
          conn_d = 1'b0;
          irq_d  = 1'b1;
          term_d = 1'b0;
        end
      end

      if (rd && dir_q == XFER_IN && full_q) begin
        full_d   = 1'b0;
        slot_clr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_q  <= 1'b0;
      dir_q   <= XFER_IN;
      even_q  <= 1'b0;
      cpw_q   <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      term_q  <= 1'b0;
      stb_q   <= 1'b0;
      ochar_q <= '0;
      opar_q  <= 1'b0;
    end else begin
      conn_q  <= conn_d;
      dir_q   <= dir_d;
      even_q  <= even_d;
      cpw_q   <= cpw_d;
      cnt_q   <= cnt_d;
      full_q  <= full_d;
      empty_q <= empty_d;
      err_q   <= err_d;
      irq_q   <= irq_d;
      term_q  <= term_d;
      stb_q   <= stb_d;
      if (stb_d) begin
        ochar_q <= ochar_d;
        opar_q  <= opar_d;
      end
    end
  end

  assign cnt       = cnt_q;
  assign even_mode = even_q;
  assign buf_empty = empty_q;
  assign ready     = (dir_q == XFER_IN) ? full_q : empty_q;
  assign error     = err_q;
  assign disc      = ~conn_q;
  assign irq       = irq_q;
  assign stb       = stb_q;
  assign ochar     = ochar_q;
  assign opar      = opar_q;

  AST_NO_STB_OFFLINE: assert property (@(posedge clk) disable iff (!rst_n)
    (!conn_q && !cmd_act) |=> !stb_q); // R10
  AST_OVERRUN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (conn_q && dir_q == XFER_IN && in_vld && full_q && !in_gap && !cmd_act && !cmd_drop)
      |=> err_q); // R5
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !rd && !cmd_act) |=> full_q); // R4
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !cmd_act) |=> irq_q); // R6
  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_drop && conn_q && !cmd_act && !irq_q) |=> (!conn_q && !irq_q)); // R10
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cpw_q); // R2
endmodule

// File: rtl/chpk_buffer.sv
module chpk_buffer #(
  parameter  int CHAR_W = 6,
  parameter  int SLOTS  = 4,
  localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int WORD_W = CHAR_W * SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_activate,
  input  logic              cfg_out,
  input  logic              cfg_even,
  input  logic [IDX_W-1:0]  cfg_cpw,
  input  logic              cmd_drop,
  input  logic              cmd_drain,
  input  logic              dev_in_vld,
  input  logic [CHAR_W-1:0] dev_in_char,
  input  logic              dev_in_par,
  input  logic              dev_in_gap,
  input  logic              dev_out_req,
  output logic              dev_out_stb,
  output logic [CHAR_W-1:0] dev_out_char,
  output logic              dev_out_par,
  input  logic              word_rd,
  output logic [WORD_W-1:0] word_rdata,
  input  logic              word_wr,
  input  logic [WORD_W-1:0] word_wdata,
  output logic              buf_ready,
  output logic              buf_error,
  output logic              dev_disc,
  output logic              irq_req
);
  logic              slot_clr, slot_ld, slot_wr;
  logic [IDX_W-1:0]  cnt;
  logic              even_mode, buf_empty;
  logic [CHAR_W-1:0] sel_char, send_char;
  logic              send_par, in_exp_par, in_par_ok;

  chpk_parity #(.W(CHAR_W)) i_in_par (
    .data      (dev_in_char),
    .even_mode (even_mode),
    .par_bit   (in_exp_par)
  );

  assign in_par_ok = (dev_in_par == in_exp_par);
  assign send_char = buf_empty ? '0 : sel_char;

  chpk_parity #(.W(CHAR_W)) i_out_par (
    .data      (send_char),
    .even_mode (even_mode),
    .par_bit   (send_par)
  );

  chpk_slots #(.CHAR_W(CHAR_W), .SLOTS(SLOTS)) i_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (slot_clr),
    .ld       (slot_ld),
    .ld_word  (word_wdata),
    .wr       (slot_wr),
    .idx      (cnt),
    .wr_char  (dev_in_char),
    .word_q   (word_rdata),
    .sel_char (sel_char)
  );

  chpk_seq #(.CHAR_W(CHAR_W), .SLOTS(SLOTS)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_act   (cmd_activate),
    .cfg_out   (cfg_out),
    .cfg_even  (cfg_even),
    .cfg_cpw   (cfg_cpw),
    .cmd_drop  (cmd_drop),
    .cmd_drain (cmd_drain),
    .in_vld    (dev_in_vld),
    .in_par_ok (in_par_ok),
    .in_gap    (dev_in_gap),
    .out_req   (dev_out_req),
    .send_char (send_char),
    .send_par  (send_par),
    .rd        (word_rd),
    .wr        (word_wr),
    .slot_clr  (slot_clr),
    .slot_ld   (slot_ld),
    .slot_wr   (slot_wr),
    .cnt       (cnt),
    .even_mode (even_mode),
    .buf_empty (buf_empty),
    .ready     (buf_ready),
    .error     (buf_error),
    .disc      (dev_disc),
    .irq       (irq_req),
    .stb       (dev_out_stb),
    .ochar     (dev_out_char),
    .opar      (dev_out_par)
  );

  AST_STB_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    dev_out_stb |-> ((^{dev_out_char, dev_out_par}) == ~even_mode)); // R7
endmodule

// File: tb/test_chpk_buffer.sv
`timescale 1ns/1ps
module test_chpk_buffer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_activate, cfg_out, cfg_even, cmd_drop, cmd_drain;
  logic [1:0]  cfg_cpw;
  logic        dev_in_vld, dev_in_par, dev_in_gap, dev_out_req;
  logic [5:0]  dev_in_char;
  logic        dev_out_stb, dev_out_par;
  logic [5:0]  dev_out_char;
  logic        word_rd, word_wr;
  logic [23:0] word_rdata, word_wdata;
  logic        buf_ready, buf_error, dev_disc, irq_req;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  chpk_buffer i_chpk_buffer (
    .clk(clk), .rst_n(rst_n), .cmd_activate(cmd_activate), .cfg_out(cfg_out),
    .cfg_even(cfg_even), .cfg_cpw(cfg_cpw), .cmd_drop(cmd_drop), .cmd_drain(cmd_drain),
    .dev_in_vld(dev_in_vld), .dev_in_char(dev_in_char), .dev_in_par(dev_in_par),
    .dev_in_gap(dev_in_gap), .dev_out_req(dev_out_req), .dev_out_stb(dev_out_stb),
    .dev_out_char(dev_out_char), .dev_out_par(dev_out_par), .word_rd(word_rd),
    .word_rdata(word_rdata), .word_wr(word_wr), .word_wdata(word_wdata),
    .buf_ready(buf_ready), .buf_error(buf_error), .dev_disc(dev_disc), .irq_req(irq_req)
  );

  // fields: even(1) cpw(2) chars(24) bad_idx(3, 7=none) exp_word(24) exp_err(1)
  localparam int NV = 6;
  localparam logic [54:0] VEC [NV] = '{
    {1'b0, 2'b11, 24'hABCDEF, 3'd7, 24'hABCDEF, 1'b0},
    {1'b1, 2'b11, 24'h123456, 3'd7, 24'h123456, 1'b0},
    {1'b0, 2'b00, 24'hFC0000, 3'd7, 24'hFC0000, 1'b0},
    {1'b1, 2'b01, 24'h555555, 3'd7, 24'h555000, 1'b0},
    {1'b0, 2'b10, 24'h0F0F0F, 3'd1, 24'h0F0F00, 1'b1},
    {1'b1, 2'b11, 24'h000000, 3'd0, 24'h000000, 1'b1}
  };

  function automatic logic par_of(input logic even, input logic [5:0] c);
    return even ? (^c) : ~(^c);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic activate(input logic out, input logic even, input logic [1:0] cpw);
    cmd_activate = 1'b1; cfg_out = out; cfg_even = even; cfg_cpw = cpw;
    tick();
    cmd_activate = 1'b0;
  endtask

  task automatic put_char(input logic [5:0] c, input logic p);
    dev_in_vld = 1'b1; dev_in_char = c; dev_in_par = p;
    tick();
    dev_in_vld = 1'b0;
  endtask

  task automatic pull_char();
    dev_out_req = 1'b1;
    tick();
    dev_out_req = 1'b0;
  endtask

  task automatic write_word(input logic [23:0] w);
    word_wr = 1'b1; word_wdata = w;
    tick();
    word_wr = 1'b0;
  endtask

  task automatic read_word();
    word_rd = 1'b1;
    tick();
    word_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmd_activate = 0; cfg_out = 0; cfg_even = 0; cfg_cpw = 0; cmd_drop = 0; cmd_drain = 0;
    dev_in_vld = 0; dev_in_char = 0; dev_in_par = 0; dev_in_gap = 0; dev_out_req = 0;
    word_rd = 0; word_wr = 0; word_wdata = 0;
    repeat (3) tick();
    chk("R1 disc", 32'(dev_disc), 1);
    chk("R1 ready", 32'(buf_ready), 0);
    chk("R1 error", 32'(buf_error), 0);
    chk("R1 irq", 32'(irq_req), 0);
    chk("R1 stb", 32'(dev_out_stb), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 disc after release", 32'(dev_disc), 1);

    // table walk: R2 packing, R3 parity, R4 read clears
    for (int v = 0; v < NV; v++) begin
      logic        ev;
      logic [1:0]  cw;
      logic [23:0] chars, expw;
      logic [2:0]  bidx;
      logic        experr;
      {ev, cw, chars, bidx, expw, experr} = VEC[v];
      activate(1'b0, ev, cw);
      for (int k = 0; k <= int'(cw); k++) begin
        logic [5:0] c;
        c = chars[23-6*k -: 6];
        if (k == int'(cw) && k > 0) chk("R2 not ready early", 32'(buf_ready), 0);
        put_char(c, par_of(ev, c) ^ (k == int'(bidx)));
      end
      chk("R2 ready", 32'(buf_ready), 1);
      chk("R2 word", 32'(word_rdata), 32'(expw));
      chk("R3 error", 32'(buf_error), 32'(experr));
      read_word();
      chk("R4 ready cleared", 32'(buf_ready), 0);
      chk("R4 word cleared", 32'(word_rdata), 0);
    end

    // R5 overrun
    activate(1'b0, 1'b0, 2'b00);
    put_char(6'h2A, par_of(1'b0, 6'h2A));
    chk("R5 error before", 32'(buf_error), 0);
    put_char(6'h15, par_of(1'b0, 6'h15));
    chk("R5 error set", 32'(buf_error), 1);
    chk("R5 word kept", 32'(word_rdata), 32'h00A80000);

    // R6 end-of-record with partial word
    activate(1'b0, 1'b0, 2'b11);
    put_char(6'h3F, par_of(1'b0, 6'h3F));
    put_char(6'h01, par_of(1'b0, 6'h01));
    dev_in_gap = 1'b1; tick(); dev_in_gap = 1'b0;
    chk("R6 disc", 32'(dev_disc), 1);
    chk("R6 irq", 32'(irq_req), 1);
    chk("R6 ready", 32'(buf_ready), 1);
    chk("R6 zero fill", 32'(word_rdata), 32'h00FC1000);
    read_word();
    // R12 ignored while disconnected
    put_char(6'h11, ~par_of(1'b0, 6'h11));
    chk("R12 ready", 32'(buf_ready), 0);
    chk("R12 word", 32'(word_rdata), 0);
    chk("R12 error", 32'(buf_error), 0);

    // R7/R8 send, three characters, odd parity
    activate(1'b1, 1'b0, 2'b10);
    chk("R8 ready empty", 32'(buf_ready), 1);
    write_word(24'h8A4C3F);
    chk("R8 ready after load", 32'(buf_ready), 0);
    write_word(24'hFFFFFF);
    pull_char();
    chk("R7 stb", 32'(dev_out_stb), 1);
    chk("R7 char0", 32'(dev_out_char), 32'h22);
    chk("R7 par0", 32'(dev_out_par), 32'(par_of(1'b0, 6'h22)));
    pull_char();
    chk("R8 char1 after ignored write", 32'(dev_out_char), 32'h24);
    chk("R8 ready mid", 32'(buf_ready), 0);
    pull_char();
    chk("R7 char2", 32'(dev_out_char), 32'h30);
    chk("R8 ready drained", 32'(buf_ready), 1);
    tick();
    chk("R7 stb one cycle", 32'(dev_out_stb), 0);
    pull_char();
    chk("R9 blank char", 32'(dev_out_char), 0);
    chk("R9 blank par odd", 32'(dev_out_par), 1);

    // R7 one-char mode, even parity; R9 blank even
    activate(1'b1, 1'b1, 2'b00);
    write_word(24'hB40000);
    pull_char();
    chk("R7 top six bits", 32'(dev_out_char), 32'h2D);
    chk("R7 even par", 32'(dev_out_par), 0);
    chk("R8 ready one char", 32'(buf_ready), 1);
    pull_char();
    chk("R9 blank even char", 32'(dev_out_char), 0);
    chk("R9 blank par even", 32'(dev_out_par), 0);

    // R11 drain then disconnect
    activate(1'b1, 1'b0, 2'b01);
    write_word(24'h123456);
    cmd_drain = 1'b1; tick(); cmd_drain = 1'b0;
    chk("R11 still connected", 32'(dev_disc), 0);
    pull_char();
    chk("R11 char0", 32'(dev_out_char), 32'h04);
    pull_char();
    chk("R11 char1", 32'(dev_out_char), 32'h23);
    chk("R11 irq not yet", 32'(irq_req), 0);
    tick();
    chk("R11 disc", 32'(dev_disc), 1);
    chk("R11 irq", 32'(irq_req), 1);

    // R10 immediate drop
    activate(1'b1, 1'b0, 2'b11);
    write_word(24'h555555);
    pull_char();
    cmd_drop = 1'b1; tick(); cmd_drop = 1'b0;
    chk("R10 disc", 32'(dev_disc), 1);
    chk("R10 no irq", 32'(irq_req), 0);
    pull_char();
    chk("R10 no stb", 32'(dev_out_stb), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule